// File: doc/BRIEF.md
# Endpoint Packet Buffer Access Engine

This block gives a processor word-by-word register access to the packet buffers of a USB-style device controller when no DMA is used. Each logical endpoint has one receive buffer, which the bus side fills and the processor drains, and one transmit buffer, which the processor fills and the bus side drains. A control write carries a read-arm bit, a write-arm bit and an endpoint number. Once the read side is armed, the block publishes the stored byte count, raises a ready flag and then hands out 32-bit words one per data-register read. Once the write side is armed, it takes a byte count and then a stream of 32-bit words.

Buffer ownership follows command pulses. A release command frees a receive buffer and a validate command marks a transmit buffer as sendable. Endpoints marked isochronous by a parameter mask follow a frame pulse instead. On such an endpoint, unread receive data is dropped at each frame, and an unvalidated transmit buffer produces an empty-packet indication.

Top module: `ep_pkt_access`

## Requirements
- R1: One cycle after a control write that arms reading on endpoint E, `rx_len_o` holds E's stored byte count (zero if E's receive buffer is empty) and `rx_rdy_o` is 1. `rx_rdy_o` stays 1 while `rd_en_o` is 1.
- R2: Each `rx_data_rd` pulse while `rd_en_o` is 1 puts the next 32-bit word of the packet on `rx_data_o` one cycle later, starting at word 0. A pulse while `rd_en_o` is 0 leaves `rx_data_o` unchanged.
- R3: The last word of a packet whose byte count L is not a multiple of 4 has only its low (L mod 4) bytes kept. The bytes above them read as zero: mask 0x000000FF, 0x0000FFFF or 0x00FFFFFF for remainders 1, 2 and 3.
- R4: The read that returns the last word also clears `rd_en_o` and sets `rx_end_o`. Arming on an empty buffer gives length 0 and `rx_rdy_o` = 1, with `rd_en_o` = 0 and `rx_end_o` = 1 at once.
- R5: A control write with the read bit at 0 stops reading and leaves the data in place. The next arm restarts at word 0.
- R6: After arming writing, a `tx_len_wr` sets the byte count L. The next ceil(L/4) `tx_data_wr` pulses store words 0, 1, 2 … of the endpoint's transmit buffer. The pulse that stores the last word clears `wr_en_o` and sets `tx_end_o`.
- R7: A control write with the write bit at 0 abandons the session. The endpoint's published transmit length keeps its old value, and the next session writes from word 0 again.
- R8: Read and write sessions may be armed together on one endpoint and proceed interleaved without disturbing each other.
- R9: On a non-isochronous endpoint, a packet arriving from the bus while the receive buffer is full is discarded. A release command empties the buffer so the next packet is taken.
- R10: `tx_ready_o[E]` rises only after a validate command for E. For a non-isochronous endpoint it falls when the bus side reports the packet sent.
- R11: An isochronous endpoint takes every arriving packet even when its buffer is full, and a frame pulse empties its receive buffer.
- R12: At a frame pulse, each isochronous endpoint whose transmit buffer is not validated pulses `iso_empty_o[E]` for one cycle. A validated one is consumed: `tx_ready_o[E]` drops and no empty pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_rd_i | input | 1 | Read-arm bit of the control write |
| ctrl_wt_i | input | 1 | Write-arm bit of the control write |
| ctrl_ep_i | input | EPW | Logical endpoint of the control write |
| rd_en_o | output | 1 | Read session active |
| wr_en_o | output | 1 | Write session active |
| rx_len_o | output | LENW | Byte count of the packet being read |
| rx_rdy_o | output | 1 | Receive length valid |
| rx_data_rd | input | 1 | Receive data register read strobe |
| rx_data_o | output | 32 | Receive data register |
| rx_end_o | output | 1 | Receive end-of-packet status |
| tx_len_wr | input | 1 | Transmit length write strobe |
| tx_len_i | input | LENW | Transmit byte count |
| tx_data_wr | input | 1 | Transmit data write strobe |
| tx_data_i | input | 32 | Transmit data word |
| tx_end_o | output | 1 | Transmit end-of-packet status |
| cmd_clr | input | 1 | Release-receive-buffer command |
| cmd_val | input | 1 | Validate-transmit-buffer command |
| cmd_ep | input | EPW | Endpoint of the command |
| frame_i | input | 1 | Frame boundary pulse |
| bus_rx_wr | input | 1 | Bus side receive word write |
| bus_rx_ep | input | EPW | Bus side receive endpoint |
| bus_rx_widx | input | WPW | Bus side receive word index |
| bus_rx_data | input | 32 | Bus side receive word |
| bus_rx_done | input | 1 | Bus side receive packet complete |
| bus_rx_len | input | LENW | Byte count of the completed packet |
| bus_tx_rd | input | 1 | Bus side transmit word read |
| bus_tx_ep | input | EPW | Bus side transmit endpoint |
| bus_tx_widx | input | WPW | Bus side transmit word index |
| bus_tx_done | input | 1 | Bus side transmit packet sent |
| bus_tx_data_o | output | 32 | Transmit word, one cycle after bus_tx_rd |
| bus_tx_len_o | output | LENW | Transmit byte count, one cycle after bus_tx_rd |
| tx_ready_o | output | NUM_EP | Per-endpoint validated flags |
| iso_empty_o | output | NUM_EP | Per-endpoint empty-packet pulses at frame |

## Verification
The assertions check several rules on every cycle. An armed read always has its ready flag up. Neither session pointer runs past the packet's word count. A session that closes without a software clear always leaves its end-of-packet status set. A full non-isochronous receive buffer never empties without a release command. A validated flag never rises without a validate command, and an empty-packet pulse never coexists with a validated buffer. Other properties need whole command sequences, and only the bench scenarios can show them. These are word order and last-word masking, the restart from word 0 after an early clear, the discarding of a packet that arrives at a full buffer, interleaved read and write on one endpoint, and the frame-driven loss and empty-packet behaviour of the isochronous endpoint.

// File: rtl/ep_pkt_pkg.sv
package ep_pkt_pkg;

  // number of 32-bit words covering a byte count
  function automatic logic [15:0] words_of(input logic [15:0] nbytes);
    return (nbytes + 16'd3) >> 2;
  endfunction

  // keep-mask for the final word, from the byte count modulo 4
  function automatic logic [31:0] lane_mask(input logic [1:0] rem);
    case (rem)
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h0000_FFFF;
      2'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/epb_ram.sv
module epb_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/epb_rx_path.sv
module epb_rx_path
  import ep_pkt_pkg::*;
#(
  parameter int                NUM_EP   = 4,
  parameter int                WORDS    = 16,
  parameter logic [NUM_EP-1:0] ISO_MASK = '0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            arm,
  input  logic                            disarm,
  input  logic [$clog2(NUM_EP)-1:0]       arm_ep,
  input  logic                            rd_pulse,
  input  logic                            clr_cmd,
  input  logic [$clog2(NUM_EP)-1:0]       cmd_ep,
  input  logic                            frame,
  input  logic                            bus_wr,
  input  logic [$clog2(NUM_EP)-1:0]       bus_ep,
  input  logic [$clog2(WORDS)-1:0]        bus_widx,
  input  logic [31:0]                     bus_wdata,
  input  logic                            bus_done,
  input  logic [$clog2(WORDS*4+1)-1:0]    bus_len,
  output logic                            rd_en,
  output logic                            rdy,
  output logic [$clog2(WORDS*4+1)-1:0]    len_o,
  output logic                            end_o,
  output logic [31:0]                     data_o
);
  localparam int EPW  = $clog2(NUM_EP);
  localparam int WPW  = $clog2(WORDS);
  localparam int LENW = $clog2(WORDS*4+1);

  logic [NUM_EP-1:0] full_q;
  logic [LENW-1:0]   len_tab [NUM_EP];
  logic [EPW-1:0]    ep_q;
  logic [WPW-1:0]    ptr_q;
  logic [31:0]       mask_q;
  logic [31:0]       ram_q;
  logic              accept, fire, at_last;
  logic [LENW-1:0]   arm_len;

  assign accept  = ISO_MASK[bus_ep] | ~full_q[bus_ep];
  assign arm_len = full_q[arm_ep] ? len_tab[arm_ep] : '0;
  assign fire    = rd_pulse & rd_en;
  assign at_last = (16'(ptr_q) == words_of(16'(len_o)) - 16'd1);

  epb_ram #(.AW(EPW + WPW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (bus_wr & accept),
    .waddr ({bus_ep, bus_widx}),
    .wdata (bus_wdata),
    .re    (fire),
    .raddr ({ep_q, ptr_q}),
    .rdata (ram_q)
  );

  assign data_o = ram_q & mask_q;

  // buffer occupancy: arrival wins over release / frame in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      for (int i = 0; i < NUM_EP; i++) len_tab[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (bus_done && bus_ep == EPW'(i) && accept) begin
          full_q[i]  <= 1'b1;
          len_tab[i] <= bus_len;
        end else if ((clr_cmd && cmd_ep == EPW'(i)) || (frame && ISO_MASK[i])) begin
          full_q[i] <= 1'b0;
        end
      end
    end
  end

  // read session
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en  <= 1'b0;
      rdy    <= 1'b0;
      len_o  <= '0;
      end_o  <= 1'b0;
      ptr_q  <= '0;
      ep_q   <= '0;
      mask_q <= '1;
    end else if (arm) begin
      ep_q  <= arm_ep;
      len_o <= arm_len;
      rdy   <= 1'b1;
      ptr_q <= '0;
      end_o <= (arm_len == '0);
      rd_en <= (arm_len != '0);
    end else if (disarm) begin
      rd_en <= 1'b0;
      rdy   <= 1'b0;
    end else if (fire) begin
      ptr_q  <= ptr_q + 1'b1;
      mask_q <= at_last ? lane_mask(len_o[1:0]) : '1;
      if (at_last) begin
        rd_en <= 1'b0;
        rdy   <= 1'b0;
        end_o <= 1'b1;
      end
    end
  end

  p_rdy_when_open_r1: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rdy);

  p_ptr_in_pkt_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (words_of(16'(len_o)) > 16'(ptr_q)));

  p_self_close_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_en) && !$past(disarm)) |-> end_o);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_hold
    if (!ISO_MASK[i]) begin : g_noniso
      p_keep_full_r9: assert property (@(posedge clk) disable iff (rst)
        (full_q[i] && !(clr_cmd && cmd_ep == EPW'(i))) |=> full_q[i]);
    end
  end
endmodule

// File: rtl/epb_tx_path.sv
module epb_tx_path
  import ep_pkt_pkg::*;
#(
  parameter int                NUM_EP   = 4,
  parameter int                WORDS    = 16,
  parameter logic [NUM_EP-1:0] ISO_MASK = '0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            arm,
  input  logic                            disarm,
  input  logic [$clog2(NUM_EP)-1:0]       arm_ep,
  input  logic                            len_wr,
  input  logic [$clog2(WORDS*4+1)-1:0]    len_in,
  input  logic                            data_wr,
  input  logic [31:0]                     data_in,
  input  logic                            val_cmd,
  input  logic [$clog2(NUM_EP)-1:0]       cmd_ep,
  input  logic                            frame,
  input  logic                            bus_rd,
  input  logic [$clog2(NUM_EP)-1:0]       bus_ep,
  input  logic [$clog2(WORDS)-1:0]        bus_widx,
  input  logic                            bus_done,
  output logic                            wr_en,
  output logic                            end_o,
  output logic [31:0]                     bus_data,
  output logic [$clog2(WORDS*4+1)-1:0]    bus_len,
  output logic [NUM_EP-1:0]               ready,
  output logic [NUM_EP-1:0]               iso_empty
);
  localparam int EPW  = $clog2(NUM_EP);
  localparam int WPW  = $clog2(WORDS);
  localparam int LENW = $clog2(WORDS*4+1);

  logic [LENW-1:0] len_tab [NUM_EP];
  logic [EPW-1:0]  ep_q;
  logic [WPW-1:0]  ptr_q;
  logic [LENW-1:0] plen_q;
  logic            len_ok_q;
  logic            put, at_last;

  assign put     = data_wr & wr_en & len_ok_q;
  assign at_last = (16'(ptr_q) == words_of(16'(plen_q)) - 16'd1);

  epb_ram #(.AW(EPW + WPW), .DW(32)) u_ram (
    .clk   (clk),
    .we    (put),
    .waddr ({ep_q, ptr_q}),
    .wdata (data_in),
    .re    (bus_rd),
    .raddr ({bus_ep, bus_widx}),
    .rdata (bus_data)
  );

  // write session; the published length changes only on completion
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      end_o    <= 1'b0;
      ep_q     <= '0;
      ptr_q    <= '0;
      plen_q   <= '0;
      len_ok_q <= 1'b0;
      for (int i = 0; i < NUM_EP; i++) len_tab[i] <= '0;
    end else if (arm) begin
      ep_q     <= arm_ep;
      wr_en    <= 1'b1;
      ptr_q    <= '0;
      len_ok_q <= 1'b0;
      end_o    <= 1'b0;
    end else if (disarm) begin
      wr_en    <= 1'b0;
      len_ok_q <= 1'b0;
    end else if (len_wr && wr_en) begin
      plen_q   <= len_in;
      ptr_q    <= '0;
      len_ok_q <= (len_in != '0);
      if (len_in == '0) begin
        wr_en         <= 1'b0;
        end_o         <= 1'b1;
        len_tab[ep_q] <= '0;
      end
    end else if (put) begin
      ptr_q <= ptr_q + 1'b1;
      if (at_last) begin
        wr_en         <= 1'b0;
        len_ok_q      <= 1'b0;
        end_o         <= 1'b1;
        len_tab[ep_q] <= plen_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_len <= '0;
    else if (bus_rd) bus_len <= len_tab[bus_ep];
  end

  // validated flags; a frame on an isochronous endpoint has the last word
  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= '0;
      iso_empty <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        iso_empty[i] <= 1'b0;
        if (val_cmd && cmd_ep == EPW'(i)) ready[i] <= 1'b1;
        if (bus_done && bus_ep == EPW'(i) && !ISO_MASK[i]) ready[i] <= 1'b0;
        if (frame && ISO_MASK[i]) begin
          iso_empty[i] <= ~ready[i];
          ready[i]     <= 1'b0;
        end
      end
    end
  end

  p_wr_ptr_in_pkt_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && len_ok_q) |-> (words_of(16'(plen_q)) > 16'(ptr_q)));

  p_close_sets_end_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(wr_en) && !$past(disarm)) |-> end_o);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_flag
    p_ready_needs_val_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(ready[i]) |-> $past(val_cmd && cmd_ep == EPW'(i)));

    p_empty_only_unready_r12: assert property (@(posedge clk) disable iff (rst)
      iso_empty[i] |-> !ready[i]);
  end
endmodule

// File: rtl/ep_pkt_access.sv
module ep_pkt_access #(
  parameter int                NUM_EP   = 4,
  parameter int                WORDS    = 16,
  parameter logic [NUM_EP-1:0] ISO_MASK = 4'b1000,
  localparam int               EPW      = $clog2(NUM_EP),
  localparam int               WPW      = $clog2(WORDS),
  localparam int               LENW     = $clog2(WORDS*4+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd_i,
  input  logic              ctrl_wt_i,
  input  logic [EPW-1:0]    ctrl_ep_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [LENW-1:0]   rx_len_o,
  output logic              rx_rdy_o,
  input  logic              rx_data_rd,
  output logic [31:0]       rx_data_o,
  output logic              rx_end_o,
  input  logic              tx_len_wr,
  input  logic [LENW-1:0]   tx_len_i,
  input  logic              tx_data_wr,
  input  logic [31:0]       tx_data_i,
  output logic              tx_end_o,
  input  logic              cmd_clr,
  input  logic              cmd_val,
  input  logic [EPW-1:0]    cmd_ep,
  input  logic              frame_i,
  input  logic              bus_rx_wr,
  input  logic [EPW-1:0]    bus_rx_ep,
  input  logic [WPW-1:0]    bus_rx_widx,
  input  logic [31:0]       bus_rx_data,
  input  logic              bus_rx_done,
  input  logic [LENW-1:0]   bus_rx_len,
  input  logic              bus_tx_rd,
  input  logic [EPW-1:0]    bus_tx_ep,
  input  logic [WPW-1:0]    bus_tx_widx,
  input  logic              bus_tx_done,
  output logic [31:0]       bus_tx_data_o,
  output logic [LENW-1:0]   bus_tx_len_o,
  output logic [NUM_EP-1:0] tx_ready_o,
  output logic [NUM_EP-1:0] iso_empty_o
);
  // a session is (re)armed only when its bit goes from clear to set
  logic rd_arm, rd_disarm, wr_arm, wr_disarm;

  assign rd_arm    = ctrl_wr &  ctrl_rd_i & ~rd_en_o;
  assign rd_disarm = ctrl_wr & ~ctrl_rd_i;
  assign wr_arm    = ctrl_wr &  ctrl_wt_i & ~wr_en_o;
  assign wr_disarm = ctrl_wr & ~ctrl_wt_i;

  epb_rx_path #(.NUM_EP(NUM_EP), .WORDS(WORDS), .ISO_MASK(ISO_MASK)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .arm       (rd_arm),
    .disarm    (rd_disarm),
    .arm_ep    (ctrl_ep_i),
    .rd_pulse  (rx_data_rd),
    .clr_cmd   (cmd_clr),
    .cmd_ep    (cmd_ep),
    .frame     (frame_i),
    .bus_wr    (bus_rx_wr),
    .bus_ep    (bus_rx_ep),
    .bus_widx  (bus_rx_widx),
    .bus_wdata (bus_rx_data),
    .bus_done  (bus_rx_done),
    .bus_len   (bus_rx_len),
    .rd_en     (rd_en_o),
    .rdy       (rx_rdy_o),
    .len_o     (rx_len_o),
    .end_o     (rx_end_o),
    .data_o    (rx_data_o)
  );

  epb_tx_path #(.NUM_EP(NUM_EP), .WORDS(WORDS), .ISO_MASK(ISO_MASK)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .arm       (wr_arm),
    .disarm    (wr_disarm),
    .arm_ep    (ctrl_ep_i),
    .len_wr    (tx_len_wr),
    .len_in    (tx_len_i),
    .data_wr   (tx_data_wr),
    .data_in   (tx_data_i),
    .val_cmd   (cmd_val),
    .cmd_ep    (cmd_ep),
    .frame     (frame_i),
    .bus_rd    (bus_tx_rd),
    .bus_ep    (bus_tx_ep),
    .bus_widx  (bus_tx_widx),
    .bus_done  (bus_tx_done),
    .wr_en     (wr_en_o),
    .end_o     (tx_end_o),
    .bus_data  (bus_tx_data_o),
    .bus_len   (bus_tx_len_o),
    .ready     (tx_ready_o),
    .iso_empty (iso_empty_o)
  );
endmodule

// File: tb/ep_pkt_access_tb.sv
`timescale 1ns/1ps
module ep_pkt_access_tb;
  localparam int NUM_EP = 4;
  localparam int WORDS  = 16;
  localparam int EPW    = 2;
  localparam int WPW    = 4;
  localparam int LENW   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic ctrl_wr = 0, ctrl_rd_i = 0, ctrl_wt_i = 0;
  logic [EPW-1:0] ctrl_ep_i = '0;
  logic rd_en_o, wr_en_o, rx_rdy_o, rx_end_o, tx_end_o;
  logic [LENW-1:0] rx_len_o, bus_tx_len_o;
  logic rx_data_rd = 0;
  logic [31:0] rx_data_o, bus_tx_data_o;
  logic tx_len_wr = 0, tx_data_wr = 0;
  logic [LENW-1:0] tx_len_i = '0;
  logic [31:0] tx_data_i = '0;
  logic cmd_clr = 0, cmd_val = 0, frame_i = 0;
  logic [EPW-1:0] cmd_ep = '0;
  logic bus_rx_wr = 0, bus_rx_done = 0, bus_tx_rd = 0, bus_tx_done = 0;
  logic [EPW-1:0] bus_rx_ep = '0, bus_tx_ep = '0;
  logic [WPW-1:0] bus_rx_widx = '0, bus_tx_widx = '0;
  logic [31:0] bus_rx_data = '0;
  logic [LENW-1:0] bus_rx_len = '0;
  logic [NUM_EP-1:0] tx_ready_o, iso_empty_o;

  ep_pkt_access #(.NUM_EP(NUM_EP), .WORDS(WORDS), .ISO_MASK(4'b1000)) u_dut (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_rd_i(ctrl_rd_i), .ctrl_wt_i(ctrl_wt_i), .ctrl_ep_i(ctrl_ep_i),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o), .rx_len_o(rx_len_o), .rx_rdy_o(rx_rdy_o),
    .rx_data_rd(rx_data_rd), .rx_data_o(rx_data_o), .rx_end_o(rx_end_o),
    .tx_len_wr(tx_len_wr), .tx_len_i(tx_len_i), .tx_data_wr(tx_data_wr), .tx_data_i(tx_data_i),
    .tx_end_o(tx_end_o), .cmd_clr(cmd_clr), .cmd_val(cmd_val), .cmd_ep(cmd_ep),
    .frame_i(frame_i), .bus_rx_wr(bus_rx_wr), .bus_rx_ep(bus_rx_ep), .bus_rx_widx(bus_rx_widx),
    .bus_rx_data(bus_rx_data), .bus_rx_done(bus_rx_done), .bus_rx_len(bus_rx_len),
    .bus_tx_rd(bus_tx_rd), .bus_tx_ep(bus_tx_ep), .bus_tx_widx(bus_tx_widx),
    .bus_tx_done(bus_tx_done), .bus_tx_data_o(bus_tx_data_o), .bus_tx_len_o(bus_tx_len_o),
    .tx_ready_o(tx_ready_o), .iso_empty_o(iso_empty_o)
  );

  int checks = 0;
  int errors = 0;

  // receive packet table: {endpoint, byte count, seed}
  localparam logic [23:0] VEC [4] = '{24'h00_08_0B, 24'h01_0D_16, 24'h02_03_21, 24'h00_40_2C};

  function automatic logic [31:0] pat(input int seed, input int k);
    return {8'(seed), 8'(k) ^ 8'hA5, 8'(seed + k), 8'(k)};
  endfunction

  function automatic logic [31:0] keep(input int len, input int k);
    int rem = len % 4;
    if (k == (len + 3) / 4 - 1 && rem != 0) return (32'h1 << (8 * rem)) - 32'h1;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl(input bit rd, input bit wt, input int ep);
    @(negedge clk);
    ctrl_wr = 1; ctrl_rd_i = rd; ctrl_wt_i = wt; ctrl_ep_i = EPW'(ep);
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic bus_load(input int ep, input int len, input int seed);
    for (int k = 0; k < (len + 3) / 4; k++) begin
      @(negedge clk);
      bus_rx_wr = 1; bus_rx_ep = EPW'(ep); bus_rx_widx = WPW'(k); bus_rx_data = pat(seed, k);
    end
    @(negedge clk);
    bus_rx_wr = 0; bus_rx_done = 1; bus_rx_ep = EPW'(ep); bus_rx_len = LENW'(len);
    @(negedge clk);
    bus_rx_done = 0;
  endtask

  task automatic rd_word();
    @(negedge clk); rx_data_rd = 1;
    @(negedge clk); rx_data_rd = 0;
  endtask

  task automatic tx_len(input int len);
    @(negedge clk); tx_len_wr = 1; tx_len_i = LENW'(len);
    @(negedge clk); tx_len_wr = 0;
  endtask

  task automatic tx_word(input logic [31:0] d);
    @(negedge clk); tx_data_wr = 1; tx_data_i = d;
    @(negedge clk); tx_data_wr = 0;
  endtask

  task automatic command(input bit clr, input bit val, input int ep);
    @(negedge clk); cmd_clr = clr; cmd_val = val; cmd_ep = EPW'(ep);
    @(negedge clk); cmd_clr = 0; cmd_val = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_i = 1;
    @(negedge clk); frame_i = 0;
  endtask

  task automatic bus_get(input int ep, input int idx);
    @(negedge clk); bus_tx_rd = 1; bus_tx_ep = EPW'(ep); bus_tx_widx = WPW'(idx);
    @(negedge clk); bus_tx_rd = 0;
  endtask

  task automatic bus_sent(input int ep);
    @(negedge clk); bus_tx_done = 1; bus_tx_ep = EPW'(ep);
    @(negedge clk); bus_tx_done = 0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ep, len, seed, nw;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    check("R1 reset rdy", 32'(rx_rdy_o), 0);
    check("R1 reset len", 32'(rx_len_o), 0);
    check("R4 reset rd_en", 32'(rd_en_o), 0);
    check("R6 reset wr_en", 32'(wr_en_o), 0);
    check("R10 reset ready", 32'(tx_ready_o), 0);
    check("R12 reset iso_empty", 32'(iso_empty_o), 0);

    // table walk: load, arm, drain, release
    for (int v = 0; v < 4; v++) begin
      ep = int'(VEC[v][23:16]); len = int'(VEC[v][15:8]); seed = int'(VEC[v][7:0]);
      nw = (len + 3) / 4;
      bus_load(ep, len, seed);
      ctrl(1, 0, ep);
      check("R1 length", 32'(rx_len_o), 32'(len));
      check("R1 ready", 32'(rx_rdy_o), 1);
      for (int k = 0; k < nw; k++) begin
        rd_word();
        if (k == nw - 1) check("R3 last word", rx_data_o, pat(seed, k) & keep(len, k));
        else             check("R2 word", rx_data_o, pat(seed, k));
      end
      check("R4 rd_en self-clear", 32'(rd_en_o), 0);
      check("R4 rx_end", 32'(rx_end_o), 1);
      command(1, 0, ep);
    end

    // R5 early stop and restart; R2 ignored read
    bus_load(2, 12, 55);
    ctrl(1, 0, 2);
    rd_word(); check("R2 word0", rx_data_o, pat(55, 0));
    rd_word(); check("R2 word1", rx_data_o, pat(55, 1));
    ctrl(0, 0, 2);
    check("R5 rd_en cleared", 32'(rd_en_o), 0);
    rd_word(); check("R2 read ignored while idle", rx_data_o, pat(55, 1));
    ctrl(1, 0, 2);
    check("R5 length kept", 32'(rx_len_o), 12);
    rd_word(); check("R5 restart at word0", rx_data_o, pat(55, 0));

    // R9 full buffer rejects, release frees
    bus_load(2, 4, 66);
    ctrl(0, 0, 2); ctrl(1, 0, 2);
    check("R9 discarded length", 32'(rx_len_o), 12);
    rd_word(); check("R9 old data kept", rx_data_o, pat(55, 0));
    ctrl(0, 0, 2);
    command(1, 0, 2);
    ctrl(1, 0, 2);
    check("R4 empty length", 32'(rx_len_o), 0);
    check("R4 empty ready", 32'(rx_rdy_o), 1);
    check("R4 empty rd_en", 32'(rd_en_o), 0);
    check("R4 empty rx_end", 32'(rx_end_o), 1);
    bus_load(2, 4, 66);
    ctrl(1, 0, 2);
    check("R9 taken after release", 32'(rx_len_o), 4);
    rd_word(); check("R9 new data", rx_data_o, pat(66, 0));

    // R6 write session, R10 validate
    ctrl(0, 1, 1);
    check("R6 wr_en armed", 32'(wr_en_o), 1);
    check("R6 tx_end cleared", 32'(tx_end_o), 0);
    tx_len(6);
    tx_word(32'h1122_3344);
    check("R6 wr_en mid", 32'(wr_en_o), 1);
    tx_word(32'h5566_7788);
    check("R6 wr_en self-clear", 32'(wr_en_o), 0);
    check("R6 tx_end", 32'(tx_end_o), 1);
    check("R10 not ready before validate", 32'(tx_ready_o[1]), 0);
    command(0, 1, 1);
    check("R10 ready after validate", 32'(tx_ready_o[1]), 1);
    bus_get(1, 1);
    check("R6 stored word1", bus_tx_data_o, 32'h5566_7788);
    check("R6 stored length", 32'(bus_tx_len_o), 6);
    bus_sent(1);
    check("R10 ready drops when sent", 32'(tx_ready_o[1]), 0);

    // R7 abandoned session restarts at word 0
    ctrl(0, 1, 1);
    tx_len(8);
    tx_word(32'hAAAA_0000);
    ctrl(0, 0, 1);
    check("R7 wr_en cleared", 32'(wr_en_o), 0);
    check("R7 no tx_end", 32'(tx_end_o), 0);
    bus_get(1, 0);
    check("R7 length unchanged", 32'(bus_tx_len_o), 6);
    ctrl(0, 1, 1);
    tx_len(8);
    tx_word(32'hBBBB_0000);
    check("R7 restart still open", 32'(wr_en_o), 1);
    tx_word(32'hCCCC_0001);
    check("R7 complete", 32'(tx_end_o), 1);
    bus_get(1, 0); check("R7 word0 rewritten", bus_tx_data_o, 32'hBBBB_0000);
    bus_get(1, 1); check("R7 word1", bus_tx_data_o, 32'hCCCC_0001);
    check("R7 new length", 32'(bus_tx_len_o), 8);

    // R8 interleaved read and write on endpoint 0
    bus_load(0, 8, 77);
    ctrl(1, 1, 0);
    check("R8 both armed", 32'({rd_en_o, wr_en_o}), 3);
    rd_word(); check("R8 read word0", rx_data_o, pat(77, 0));
    tx_len(4);
    tx_word(32'hD00D_0001);
    check("R8 write done", 32'({wr_en_o, tx_end_o}), 1);
    check("R8 read still open", 32'(rd_en_o), 1);
    rd_word(); check("R8 read word1", rx_data_o, pat(77, 1));
    check("R8 read done", 32'({rd_en_o, rx_end_o}), 1);
    bus_get(0, 0); check("R8 written word", bus_tx_data_o, 32'hD00D_0001);

    // R11 isochronous endpoint 3 receive side
    bus_load(3, 4, 88);
    bus_load(3, 8, 99);
    ctrl(1, 0, 3);
    check("R11 overwrite accepted", 32'(rx_len_o), 8);
    rd_word(); check("R11 newest data", rx_data_o, pat(99, 0));
    ctrl(0, 0, 3);
    pulse_frame();
    ctrl(1, 0, 3);
    check("R11 frame drops data", 32'(rx_len_o), 0);

    // R12 isochronous transmit side
    pulse_frame();
    check("R12 empty pulse", 32'(iso_empty_o), 32'h8);
    @(negedge clk);
    check("R12 pulse one cycle", 32'(iso_empty_o), 0);
    command(0, 1, 3);
    check("R12 validated", 32'(tx_ready_o[3]), 1);
    pulse_frame();
    check("R12 no empty when validated", 32'(iso_empty_o), 0);
    check("R12 consumed at frame", 32'(tx_ready_o[3]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule